// File: doc/BRIEF.md
# I2S Receive Bit-Clock and Word-Select Source Selector

This block produces the timing an I2S receiver needs, all in the system clock domain. The bit clock appears as a single-cycle enable pulse, and the word-select appears as a level. A fractional accumulator scales the system clock by X/Y, and a fixed halving stage follows it to give the receiver's own reference pulse. An integer divider then turns the chosen reference into bit-clock pulses.

A four-bit source code and a slave flag pick where the timing comes from:
- the receiver's own divided reference;
- the transmitter's reference pulse, divided by the same integer divider;
- the transmitter's bit clock and word-select, passed straight through (4-wire receive);
- external bit-clock and word-select pins, synchronised and edge-detected.

In master operation the block makes its own word-select. It toggles that level after a programmable number of bit clocks. The top bit of the source code drives the enable of the master-clock output pin.

Any change to a configuration input restarts every counter. This keeps a partial period from reaching the output.

Top module: `i2s_rx_clk_sel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `bclk_en`, `ref_en` and `ws_out` are 0.
- R2: `ref_en` pulses at an average rate of `frac_num`/(2·`frac_den`) per system clock. The tolerance is two pulses over any window. If `frac_num` is 0 or exceeds `frac_den`, `ref_en` never pulses.
- R3: `ref_en` is never high on two consecutive cycles.
- R4: With `src_mode[2:0]`=000 and `slave`=0, `bclk_en` pulses once per `bit_div`+1 pulses of the own reference. With X=Y this gives a spacing of 2·(`bit_div`+1) cycles.
- R5: With `src_mode[2:0]`=010, the integer divider counts `tx_ref_en` pulses instead of the own reference. The spacing is the transmitter reference period times (`bit_div`+1), whether `slave` is 0 or 1.
- R6: With `src_mode[2:0]`=100, `bclk_en` equals `tx_bclk_en` and `ws_out` equals `tx_ws` in the same cycle, for either value of `slave`.
- R7: With `slave`=1 and `src_mode[2:0]` neither 010 nor 100, each rising edge of `rx_sck_pin` gives exactly one `bclk_en` pulse two clocks after it is sampled. A falling edge gives none.
- R8: In master operation outside code 100, `ws_out` starts at 0 after reset or a configuration change. It then toggles after every `ws_len`+1 bit-clock pulses.
- R9: `mclk_oe` equals `src_mode[3]`.
- R10: A change of any configuration input clears all dividers on the next clock edge. With X=Y and code 000 master, the first `bclk_en` pulse is sampled 2·`bit_div`+4 falling edges after the change.
- R11: With `slave`=1 outside code 100, `ws_out` follows `rx_ws_pin` with a two-clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frac_num | input | 8 | Fractional divider numerator X |
| frac_den | input | 8 | Fractional divider denominator Y |
| bit_div | input | 6 | Bit-clock ratio minus one |
| src_mode | input | 4 | Source code; bit 3 enables master clock out |
| slave | input | 1 | 1 selects slave operation |
| ws_len | input | 5 | Bit clocks per word-select half, minus one |
| rx_sck_pin | input | 1 | External receive bit clock (asynchronous) |
| rx_ws_pin | input | 1 | External receive word-select (asynchronous) |
| tx_ref_en | input | 1 | Transmitter reference pulse |
| tx_bclk_en | input | 1 | Transmitter bit-clock pulse |
| tx_ws | input | 1 | Transmitter word-select |
| ref_en | output | 1 | Own receive reference pulse |
| bclk_en | output | 1 | Selected receive bit-clock pulse |
| ws_out | output | 1 | Selected receive word-select |
| mclk_oe | output | 1 | Master-clock pin output enable |

## Verification
The hardest case to reach is the restart on a configuration change. Its effect can only be seen as the phase of the first bit clock afterwards, so the stimulus runs the divider at one ratio first. It then changes `bit_div` at a known falling edge and counts edges until the first pulse. Any leftover accumulator, halving or counter state would shift that count. The fractional accumulator is swept over every X up to 7 against Y from 1 to 6, which includes the ratios that must stay silent. The external-pin path is checked edge by edge for its exact two-clock latency.

// File: rtl/i2s_rxclk_pkg.sv
package i2s_rxclk_pkg;
  localparam int FRAC_W_DEF = 8;
  localparam int BDIV_W_DEF = 6;
  localparam int WSL_W_DEF  = 5;
  localparam int SYNC_DEF   = 2;
  // source codes on mode bits [2:0]; any other code behaves like OWN
  localparam logic [2:0] SRC_OWN    = 3'b000;
  localparam logic [2:0] SRC_TXREF  = 3'b010;
  localparam logic [2:0] SRC_FOURW  = 3'b100;
endpackage

// File: rtl/rxc_frac_div.sv
module rxc_frac_div #(
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [FRAC_W-1:0] num,
  input  logic [FRAC_W-1:0] den,
  output logic              ref_en
);
  localparam int ACC_W = FRAC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d, sum;
  logic             tog_q, tog_d, ref_q, ref_d;
  logic             valid, hit;

  always_comb begin
    valid = (num != '0) && (num <= den);
    sum   = acc_q + {1'b0, num};
    hit   = valid && (sum >= {1'b0, den});
    acc_d = acc_q;
    tog_d = tog_q;
    ref_d = 1'b0;
    if (clr) begin
      acc_d = '0;
      tog_d = 1'b0;
    end else begin
      if (!valid)   acc_d = '0;
      else if (hit) acc_d = sum - {1'b0, den};
      else          acc_d = sum;
      tog_d = tog_q ^ hit;
      ref_d = hit & tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tog_q <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      tog_q <= tog_d;
      ref_q <= ref_d;
    end
  end

  assign ref_en = ref_q;

  p_no_ref_bad_ratio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((num == '0) || (num > den)) |=> !ref_en)
    else $error("reference pulse with unusable ratio");

  p_ref_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en |=> !ref_en)
    else $error("reference pulses back to back");
endmodule

// File: rtl/rxc_pulse_div.sv
module rxc_pulse_div #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_en,
  input  logic [CNT_W-1:0] div,
  output logic             out_en
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (in_en) begin
      if (cnt_q >= div) begin
        cnt_d = '0;
        out_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign out_en = out_q;

  p_out_needs_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> ($past(in_en) && !$past(clr)))
    else $error("divided pulse without input pulse");
endmodule

// File: rtl/rxc_pin_sync.sv
module rxc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_pin,
  input  logic ws_pin,
  output logic sck_rise,
  output logic ws_lvl
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sck_sh_q, sck_sh_d, ws_sh_q, ws_sh_d;
  logic              sck_old_q;

  always_comb begin
    sck_sh_d = {sck_sh_q[LAST-1:0], sck_pin};
    ws_sh_d  = {ws_sh_q[LAST-1:0], ws_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh_q  <= '0;
      ws_sh_q   <= '0;
      sck_old_q <= 1'b0;
    end else begin
      sck_sh_q  <= sck_sh_d;
      ws_sh_q   <= ws_sh_d;
      sck_old_q <= sck_sh_q[LAST];
    end
  end

  assign sck_rise = sck_sh_q[LAST] & ~sck_old_q;
  assign ws_lvl   = ws_sh_q[LAST];

  p_single_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_rise)
    else $error("two edge pulses from one pin edge");
endmodule

// File: rtl/rxc_ws_gen.sv
module rxc_ws_gen #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [LEN_W-1:0] half_len,
  output logic             ws
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             ws_q, ws_d;

  always_comb begin
    cnt_d = cnt_q;
    ws_d  = ws_q;
    if (clr) begin
      cnt_d = '0;
      ws_d  = 1'b0;
    end else if (tick) begin
      if (cnt_q >= half_len) begin
        cnt_d = '0;
        ws_d  = ~ws_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ws_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ws_q  <= ws_d;
    end
  end

  assign ws = ws_q;

  p_ws_moves_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ws != $past(ws)) |-> ($past(tick) || $past(clr)))
    else $error("word-select moved without a bit clock");
endmodule

// File: rtl/i2s_rx_clk_sel.sv
module i2s_rx_clk_sel
  import i2s_rxclk_pkg::*;
#(
  parameter int FRAC_W = FRAC_W_DEF,
  parameter int BDIV_W = BDIV_W_DEF,
  parameter int WSL_W  = WSL_W_DEF,
  parameter int SYNC_N = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] frac_num,
  input  logic [FRAC_W-1:0] frac_den,
  input  logic [BDIV_W-1:0] bit_div,
  input  logic [3:0]        src_mode,
  input  logic              slave,
  input  logic [WSL_W-1:0]  ws_len,
  input  logic              rx_sck_pin,
  input  logic              rx_ws_pin,
  input  logic              tx_ref_en,
  input  logic              tx_bclk_en,
  input  logic              tx_ws,
  output logic              ref_en,
  output logic              bclk_en,
  output logic              ws_out,
  output logic              mclk_oe
);
  localparam int CFG_W = 2 * FRAC_W + BDIV_W + 4 + 1 + WSL_W;

  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             cfg_chg;
  logic             own_ref, div_in, div_bclk;
  logic             sck_rise, ws_sync, ws_gen_lvl;
  logic             four_wire, txref_sel, ext_clk;

  // configuration snapshot: any difference restarts all counters
  assign cfg_now = {frac_num, frac_den, bit_div, src_mode, slave, ws_len};
  assign cfg_chg = (cfg_now != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_now;
  end

  always_comb begin
    four_wire = (src_mode[2:0] == SRC_FOURW);
    txref_sel = (src_mode[2:0] == SRC_TXREF);
    ext_clk   = slave && !four_wire && !txref_sel;
    div_in    = txref_sel ? tx_ref_en : own_ref;
  end

  rxc_frac_div #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .clr(cfg_chg),
    .num(frac_num), .den(frac_den), .ref_en(own_ref)
  );

  rxc_pulse_div #(.CNT_W(BDIV_W)) u_bdiv (
    .clk(clk), .rst_n(rst_n), .clr(cfg_chg),
    .in_en(div_in), .div(bit_div), .out_en(div_bclk)
  );

  rxc_pin_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_pin(rx_sck_pin), .ws_pin(rx_ws_pin),
    .sck_rise(sck_rise), .ws_lvl(ws_sync)
  );

  rxc_ws_gen #(.LEN_W(WSL_W)) u_wsg (
    .clk(clk), .rst_n(rst_n), .clr(cfg_chg),
    .tick(div_bclk), .half_len(ws_len), .ws(ws_gen_lvl)
  );

  always_comb begin
    if (four_wire)    bclk_en = tx_bclk_en;
    else if (ext_clk) bclk_en = sck_rise;
    else              bclk_en = div_bclk;
    if (four_wire)    ws_out = tx_ws;
    else if (slave)   ws_out = ws_sync;
    else              ws_out = ws_gen_lvl;
  end

  assign ref_en  = own_ref;
  assign mclk_oe = src_mode[3];

  p_ext_edge_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk && $past(ext_clk) && bclk_en) |-> $past(rx_sck_pin, 2))
    else $error("external bit clock pulse without pin high");
endmodule

// File: tb/test_i2s_rx_clk_sel.sv
module test_i2s_rx_clk_sel;
  logic       clk, rst_n;
  logic [7:0] frac_num, frac_den;
  logic [5:0] bit_div;
  logic [3:0] src_mode;
  logic       slave;
  logic [4:0] ws_len;
  logic       rx_sck_pin, rx_ws_pin, tx_ref_en, tx_bclk_en, tx_ws;
  logic       ref_en, bclk_en, ws_out, mclk_oe;

  int  n_chk = 0, n_bad = 0, cyc = 0;
  bit  done = 0, txref_on = 0;
  int  tr_cnt = 0;

  i2s_rx_clk_sel i_i2s_rx_clk_sel (
    .clk(clk), .rst_n(rst_n), .frac_num(frac_num), .frac_den(frac_den),
    .bit_div(bit_div), .src_mode(src_mode), .slave(slave), .ws_len(ws_len),
    .rx_sck_pin(rx_sck_pin), .rx_ws_pin(rx_ws_pin), .tx_ref_en(tx_ref_en),
    .tx_bclk_en(tx_bclk_en), .tx_ws(tx_ws), .ref_en(ref_en),
    .bclk_en(bclk_en), .ws_out(ws_out), .mclk_oe(mclk_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // transmitter reference: one pulse every 3 cycles when enabled
  always @(negedge clk) begin
    if (txref_on) begin
      tx_ref_en <= (tr_cnt == 0);
      tr_cnt    <= (tr_cnt == 2) ? 0 : tr_cnt + 1;
    end else begin
      tx_ref_en <= 1'b0;
      tr_cnt    <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic setcfg(input int x, input int y, input int d, input int m,
                        input bit s, input int w);
    @(negedge clk);
    frac_num = 8'(x); frac_den = 8'(y); bit_div = 6'(d);
    src_mode = 4'(m); slave = s; ws_len = 5'(w);
    repeat (3) @(negedge clk);
  endtask

  task automatic next_bclk(output int at);
    int g = 0;
    do begin @(negedge clk); g++; end while (!bclk_en && g < 2000);
    at = bclk_en ? cyc : -1;
  endtask

  task automatic bclk_spacing(output int sp);
    int a, b;
    next_bclk(a);
    next_bclk(b);
    sp = (a < 0 || b < 0) ? -1 : b - a;
  endtask

  task automatic next_ws_change(output int at);
    int g = 0;
    logic old = ws_out;
    do begin @(negedge clk); g++; end while (ws_out == old && g < 2000);
    at = (ws_out != old) ? cyc : -1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int sp, a, b, cnt, k;
    bit prev, dbl;
    rst_n = 0; frac_num = 0; frac_den = 0; bit_div = 0; src_mode = 0;
    slave = 0; ws_len = 0; rx_sck_pin = 0; rx_ws_pin = 0;
    tx_bclk_en = 0; tx_ws = 0;
    repeat (3) @(negedge clk);
    check(!bclk_en && !ref_en && !ws_out, "R1 in reset", {bclk_en, ref_en, ws_out}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!bclk_en && !ref_en && !ws_out, "R1 after reset", {bclk_en, ref_en, ws_out}, 0);

    // R2/R3: fractional sweep
    for (int y = 1; y <= 6; y++) begin
      for (int x = 0; x <= 7; x++) begin
        setcfg(x, y, 0, 0, 0, 0);
        cnt = 0; prev = 0; dbl = 0;
        for (int i = 0; i < 200; i++) begin
          @(negedge clk);
          if (ref_en) cnt++;
          if (ref_en && prev) dbl = 1;
          prev = ref_en;
        end
        if (x == 0 || x > y)
          check(cnt == 0, "R2 silent ratio", cnt, 0);
        else
          check((cnt * 2 * y - 200 * x) <= 4 * y && (200 * x - cnt * 2 * y) <= 4 * y,
                "R2 rate", cnt, (200 * x) / (2 * y));
        check(!dbl, "R3 no consecutive ref", dbl, 0);
      end
    end

    // R4: own reference bit divider
    for (int d = 0; d < 6; d++) begin
      setcfg(1, 1, d, 0, 0, 0);
      bclk_spacing(sp);
      check(sp == 2 * (d + 1), "R4 own bclk spacing", sp, 2 * (d + 1));
    end

    // R5: transmitter reference, master and slave
    txref_on = 1;
    for (int d = 0; d < 4; d++) begin
      for (int s = 0; s < 2; s++) begin
        setcfg(0, 0, d, 4'b0010, s[0], 0);
        bclk_spacing(sp);
        check(sp == 3 * (d + 1), "R5 tx-ref bclk spacing", sp, 3 * (d + 1));
      end
    end
    // R11: slave word-select with tx-ref code
    @(negedge clk); rx_ws_pin = 1;
    @(negedge clk); check(ws_out == 0, "R11 ws before latency", ws_out, 0);
    @(negedge clk); check(ws_out == 1, "R11 ws after two clocks", ws_out, 1);
    rx_ws_pin = 0;
    repeat (2) @(negedge clk);
    check(ws_out == 0, "R11 ws returns low", ws_out, 0);
    txref_on = 0;

    // R6: four-wire pass-through
    for (int s = 0; s < 2; s++) begin
      setcfg(1, 1, 0, 4'b0100, s[0], 0);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        tx_bclk_en = i[0] ^ i[2]; tx_ws = i[1];
        #1;
        check(bclk_en == tx_bclk_en, "R6 bclk follows tx", bclk_en, tx_bclk_en);
        check(ws_out == tx_ws, "R6 ws follows tx", ws_out, tx_ws);
      end
      tx_bclk_en = 0; tx_ws = 0;
    end

    // R7: external pin edges in slave code 000
    setcfg(1, 1, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) begin
      rx_sck_pin = 1;
      @(negedge clk); check(!bclk_en, "R7 no pulse after one clock", bclk_en, 0);
      @(negedge clk); check(bclk_en, "R7 pulse after two clocks", bclk_en, 1);
      @(negedge clk); check(!bclk_en, "R7 single pulse", bclk_en, 0);
      rx_sck_pin = 0;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk); check(!bclk_en, "R7 falling edge silent", bclk_en, 0);
      end
    end
    // R11 with code 000 slave
    rx_ws_pin = 1;
    @(negedge clk); check(ws_out == 0, "R11 pin ws latency", ws_out, 0);
    @(negedge clk); check(ws_out == 1, "R11 pin ws follows", ws_out, 1);
    rx_ws_pin = 0;

    // R8: master word-select period
    for (int d = 0; d < 2; d++) begin
      for (int w = 0; w < 4; w++) begin
        setcfg(1, 1, d, 0, 0, w);
        next_ws_change(a);
        next_ws_change(b);
        sp = (a < 0 || b < 0) ? -1 : b - a;
        check(sp == 2 * (d + 1) * (w + 1), "R8 ws toggle spacing", sp, 2 * (d + 1) * (w + 1));
      end
    end

    // R9: master-clock enable
    for (int m = 0; m < 16; m += 4) begin
      @(negedge clk); src_mode = 4'(m | 8); #1;
      check(mclk_oe == 1, "R9 mclk_oe set", mclk_oe, 1);
      src_mode = 4'(m & 7); #1;
      check(mclk_oe == 0, "R9 mclk_oe clear", mclk_oe, 0);
    end

    // R10: restart phase after a divider change
    setcfg(1, 1, 5, 0, 0, 0);
    repeat (17) @(negedge clk);
    for (int d = 0; d < 4; d++) begin
      @(negedge clk);
      bit_div = 6'(d);
      k = 0;
      do begin @(negedge clk); k++; end while (!bclk_en && k < 100);
      check(k == 2 * d + 4, "R10 first pulse after change", k, 2 * d + 4);
      repeat (7) @(negedge clk);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule